// File: doc/BRIEF.md
# D-PHY Lane High-Speed Timing Sequencer

This block drives the timing of one transmit lane of a MIPI D-PHY. Clocked by the lane byte clock, it walks the lane from the low-power stop state into high-speed mode and back again. Every phase length comes from a count input, sampled at the moment the phase is entered. The same block serves a clock lane or a data lane, selected by one input. The two lane types differ in their hs_zero count and in the extra clock-lane phases before and after the payload. Serialisation and the analog drivers sit outside; this block only tells them which line state to produce.

While the lane rests in the stop state, a turnaround request runs three timers back to back. These timers count ticks of an escape-clock enable. That enable is a one-cycle strobe produced elsewhere from the byte clock, and escape-clock phases advance only on it. Control is by levels: `hs_request` is held high for as long as high-speed data is wanted. `hs_ready` tells the data source that payload may flow. Hold-off is expressed by `hs_ready` staying low. When `hs_request` falls, the lane leaves high speed only once `hs_ready` is set.

Top module: `dphy_lane_seq`

## Requirements
- R1: While reset is active and right after it, phase is idle (code 0), lane_state is stop (code 0) and hs_ready is low.
- R2: In idle the lane stays in stop until hs_request is seen high at a clock edge. The next phase is then LPX (code 1), followed in order by prepare (2), zero (3) and payload (4). If hs_request and ta_request are both high in idle, the high-speed entry is taken.
- R3: The LPX phase lasts lpx_cnt + 2 byte-clock cycles, so a zero count gives two cycles.
- R4: Prepare lasts prep_cnt cycles and trail (code 6) lasts trail_cnt cycles. A count of zero gives one cycle. Each count is sampled when its phase is entered.
- R5: The zero phase length is a 7-bit value: the hi field in bit 6 and the lo field in bits 5:0. It is taken from the clock-lane pair when lane_is_clk is 1 and from the data-lane pair otherwise. A value of zero gives one cycle.
- R6: The payload phase holds for as long as hs_request stays high. On a data lane hs_ready is high from the first payload cycle, and the cycle after hs_request is seen low the phase is trail.
- R7: On a clock lane hs_ready rises in the pre_cnt-th payload cycle (the first cycle when pre_cnt is 0). A drop of hs_request before then does not end the payload phase.
- R8: On a clock lane, leaving payload enters the post phase (code 5). Its length is {post_hi, post_lo} cycles, with a minimum of one. Trail follows.
- R9: After trail, the exit phase (code 7) lasts {exit_hi, exit_lo} cycles (5 lo bits), with a minimum of one, and then the lane returns to idle.
- R10: With ta_request high in idle and hs_request low, phases go through ta-go (8), ta-sure (9) and ta-wait (10) and then back to idle. Each of these lasts its 6-bit count in esc_en ticks, with a minimum of one tick. Cycles without esc_en never advance them.
- R11: lane_state encodes the phases as follows: idle = stop 0, LPX = 1, prepare = 2, zero = 3, payload and post = 4, trail = 5, exit = 6, and any turnaround phase = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_en | input | 1 | One-cycle escape-clock tick |
| lane_is_clk | input | 1 | 1 = clock lane, 0 = data lane |
| hs_request | input | 1 | Level request for high-speed transmission |
| ta_request | input | 1 | Level request for a turnaround sequence |
| lpx_cnt | input | 6 | LPX count (adds 2 cycles) |
| prep_cnt | input | 7 | Prepare count |
| zero_clk_hi | input | 1 | Clock-lane zero count, bit 6 |
| zero_clk_lo | input | 6 | Clock-lane zero count, bits 5:0 |
| zero_dat_hi | input | 1 | Data-lane zero count, bit 6 |
| zero_dat_lo | input | 6 | Data-lane zero count, bits 5:0 |
| trail_cnt | input | 7 | Trail count |
| exit_hi | input | 1 | Exit count, bit 5 |
| exit_lo | input | 5 | Exit count, bits 4:0 |
| post_hi | input | 2 | Clock post count, bits 5:4 |
| post_lo | input | 4 | Clock post count, bits 3:0 |
| pre_cnt | input | 4 | Clock pre count |
| ta_go_cnt | input | 6 | Turnaround go count, in escape ticks |
| ta_sure_cnt | input | 6 | Turnaround sure count, in escape ticks |
| ta_wait_cnt | input | 6 | Turnaround wait count, in escape ticks |
| lane_state | output | 3 | Line state code (R11) |
| phase | output | 4 | Phase code (R2 to R10) |
| hs_ready | output | 1 | Payload may flow |

## Verification
The bench builds the block with its default field widths, so every count can be driven to its full range: a 65-cycle LPX, a 127-cycle zero phase, a 63-cycle exit and a 63-tick turnaround wait. A behavioural model in the bench predicts phase, lane state and hs_ready on every cycle. It exercises both lane types, including a request drop before the clock lane is ready. It also covers simultaneous high-speed and turnaround requests, and an escape tick that arrives only every fourth cycle, so the hold behaviour between ticks is visible.

// File: rtl/dphy_lane_seq_pkg.sv
package dphy_lane_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE    = 4'd0,
    PH_LPX     = 4'd1,
    PH_PREP    = 4'd2,
    PH_ZERO    = 4'd3,
    PH_HS      = 4'd4,
    PH_POST    = 4'd5,
    PH_TRAIL   = 4'd6,
    PH_EXIT    = 4'd7,
    PH_TA_GO   = 4'd8,
    PH_TA_SURE = 4'd9,
    PH_TA_WAIT = 4'd10
  } phase_e;

  typedef enum logic [2:0] {
    LN_STOP  = 3'd0,
    LN_LP01  = 3'd1,
    LN_LP00  = 3'd2,
    LN_HS0   = 3'd3,
    LN_HSDAT = 3'd4,
    LN_TRAIL = 3'd5,
    LN_EXIT  = 3'd6,
    LN_TA    = 3'd7
  } line_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dls_field_join.sv
module dls_field_join #(
  parameter int HI_W = 1,
  parameter int LO_W = 6,
  localparam int OUT_W = HI_W + LO_W
) (
  input  logic [HI_W-1:0]  hi,
  input  logic [LO_W-1:0]  lo,
  output logic [OUT_W-1:0] joined
);
  assign joined = {hi, lo};
endmodule

// File: rtl/dls_down_counter.sv
module dls_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         at_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (step)   cnt_q <= cnt_q - W'(1);
  end

  assign at_zero = (cnt_q == '0);

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && at_zero) |=> 1'b0);
endmodule

// File: rtl/dls_line_map.sv
module dls_line_map
  import dphy_lane_seq_pkg::*;
(
  input  phase_e ph,
  output line_e  line
);
  always_comb begin
    unique case (ph)
      PH_IDLE:                          line = LN_STOP;
      PH_LPX:                           line = LN_LP01;
      PH_PREP:                          line = LN_LP00;
      PH_ZERO:                          line = LN_HS0;
      PH_HS, PH_POST:                   line = LN_HSDAT;
      PH_TRAIL:                         line = LN_TRAIL;
      PH_EXIT:                          line = LN_EXIT;
      PH_TA_GO, PH_TA_SURE, PH_TA_WAIT: line = LN_TA;
      default:                          line = LN_STOP;
    endcase
  end
endmodule

// File: rtl/dls_phase_ctrl.sv
module dls_phase_ctrl
  import dphy_lane_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esc_en,
  input  logic             lane_is_clk,
  input  logic             hs_request,
  input  logic             ta_request,
  input  logic [CNT_W-1:0] lpx_v,
  input  logic [CNT_W-1:0] prep_v,
  input  logic [CNT_W-1:0] zero_v,
  input  logic [CNT_W-1:0] trail_v,
  input  logic [CNT_W-1:0] exit_v,
  input  logic [CNT_W-1:0] post_v,
  input  logic [CNT_W-1:0] pre_v,
  input  logic [CNT_W-1:0] ta_go_v,
  input  logic [CNT_W-1:0] ta_sure_v,
  input  logic [CNT_W-1:0] ta_wait_v,
  output phase_e           ph,
  output logic             ready
);
  phase_e           ph_q, ph_d;
  logic             ld, step, at_zero;
  logic [CNT_W-1:0] ld_val;

  function automatic logic [CNT_W-1:0] less1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  dls_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .step     (step),
    .at_zero  (at_zero)
  );

  always_comb begin
    ph_d   = ph_q;
    ld     = 1'b0;
    ld_val = '0;
    step   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (hs_request) begin
          ph_d = PH_LPX;   ld = 1'b1; ld_val = lpx_v + CNT_W'(1);
        end else if (ta_request) begin
          ph_d = PH_TA_GO; ld = 1'b1; ld_val = less1(ta_go_v);
        end
      end
      PH_LPX: begin
        if (!at_zero) step = 1'b1;
        else begin ph_d = PH_PREP; ld = 1'b1; ld_val = less1(prep_v); end
      end
      PH_PREP: begin
        if (!at_zero) step = 1'b1;
        else begin ph_d = PH_ZERO; ld = 1'b1; ld_val = less1(zero_v); end
      end
      PH_ZERO: begin
        if (!at_zero) step = 1'b1;
        else begin
          ph_d = PH_HS; ld = 1'b1;
          ld_val = lane_is_clk ? less1(pre_v) : '0;
        end
      end
      PH_HS: begin
        if (!at_zero) step = 1'b1;
        else if (!hs_request) begin
          ld = 1'b1;
          if (lane_is_clk) begin ph_d = PH_POST;  ld_val = less1(post_v);  end
          else             begin ph_d = PH_TRAIL; ld_val = less1(trail_v); end
        end
      end
      PH_POST: begin
        if (!at_zero) step = 1'b1;
        else begin ph_d = PH_TRAIL; ld = 1'b1; ld_val = less1(trail_v); end
      end
      PH_TRAIL: begin
        if (!at_zero) step = 1'b1;
        else begin ph_d = PH_EXIT; ld = 1'b1; ld_val = less1(exit_v); end
      end
      PH_EXIT: begin
        if (!at_zero) step = 1'b1;
        else ph_d = PH_IDLE;
      end
      PH_TA_GO: begin
        if (esc_en) begin
          if (!at_zero) step = 1'b1;
          else begin ph_d = PH_TA_SURE; ld = 1'b1; ld_val = less1(ta_sure_v); end
        end
      end
      PH_TA_SURE: begin
        if (esc_en) begin
          if (!at_zero) step = 1'b1;
          else begin ph_d = PH_TA_WAIT; ld = 1'b1; ld_val = less1(ta_wait_v); end
        end
      end
      PH_TA_WAIT: begin
        if (esc_en) begin
          if (!at_zero) step = 1'b1;
          else ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign ph    = ph_q;
  assign ready = (ph_q == PH_HS) && at_zero;

  assert_lpx_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_q == PH_LPX) |=> (ph_q == PH_LPX));

  assert_prep_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PREP && $past(ph_q) != PH_PREP) |-> ($past(ph_q) == PH_LPX));

  assert_zero_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ZERO && $past(ph_q) != PH_ZERO) |-> ($past(ph_q) == PH_PREP));

  assert_hs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HS && hs_request) |=> (ph_q == PH_HS));

  assert_pre_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HS && !ready) |=> (ph_q == PH_HS));

  assert_post_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_POST && $past(ph_q) == PH_HS) |-> $past(lane_is_clk));

  assert_back_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && $past(ph_q) != PH_IDLE) |->
      ($past(ph_q) == PH_EXIT || $past(ph_q) == PH_TA_WAIT));

  assert_ta_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_TA_GO || ph_q == PH_TA_SURE || ph_q == PH_TA_WAIT) && !esc_en)
      |=> $stable(ph_q));
endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
  import dphy_lane_seq_pkg::*;
#(
  parameter int LPX_W     = 6,
  parameter int PREP_W    = 7,
  parameter int ZERO_HI_W = 1,
  parameter int ZERO_LO_W = 6,
  parameter int TRAIL_W   = 7,
  parameter int EXIT_HI_W = 1,
  parameter int EXIT_LO_W = 5,
  parameter int POST_HI_W = 2,
  parameter int POST_LO_W = 4,
  parameter int PRE_W     = 4,
  parameter int TA_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 esc_en,
  input  logic                 lane_is_clk,
  input  logic                 hs_request,
  input  logic                 ta_request,
  input  logic [LPX_W-1:0]     lpx_cnt,
  input  logic [PREP_W-1:0]    prep_cnt,
  input  logic [ZERO_HI_W-1:0] zero_clk_hi,
  input  logic [ZERO_LO_W-1:0] zero_clk_lo,
  input  logic [ZERO_HI_W-1:0] zero_dat_hi,
  input  logic [ZERO_LO_W-1:0] zero_dat_lo,
  input  logic [TRAIL_W-1:0]   trail_cnt,
  input  logic [EXIT_HI_W-1:0] exit_hi,
  input  logic [EXIT_LO_W-1:0] exit_lo,
  input  logic [POST_HI_W-1:0] post_hi,
  input  logic [POST_LO_W-1:0] post_lo,
  input  logic [PRE_W-1:0]     pre_cnt,
  input  logic [TA_W-1:0]      ta_go_cnt,
  input  logic [TA_W-1:0]      ta_sure_cnt,
  input  logic [TA_W-1:0]      ta_wait_cnt,
  output logic [2:0]           lane_state,
  output logic [3:0]           phase,
  output logic                 hs_ready
);
  localparam int ZERO_W = ZERO_HI_W + ZERO_LO_W;
  localparam int EXIT_W = EXIT_HI_W + EXIT_LO_W;
  localparam int POST_W = POST_HI_W + POST_LO_W;
  localparam int CNT_W  = max2(max2(max2(LPX_W + 1, PREP_W), max2(ZERO_W, TRAIL_W)),
                               max2(max2(EXIT_W, POST_W), max2(PRE_W, TA_W)));

  logic [ZERO_W-1:0] zero_clk, zero_dat, zero_sel;
  logic [EXIT_W-1:0] exit_j;
  logic [POST_W-1:0] post_j;
  phase_e            ph;
  line_e             line;

  dls_field_join #(.HI_W(ZERO_HI_W), .LO_W(ZERO_LO_W)) u_zc (
    .hi(zero_clk_hi), .lo(zero_clk_lo), .joined(zero_clk));
  dls_field_join #(.HI_W(ZERO_HI_W), .LO_W(ZERO_LO_W)) u_zd (
    .hi(zero_dat_hi), .lo(zero_dat_lo), .joined(zero_dat));
  dls_field_join #(.HI_W(EXIT_HI_W), .LO_W(EXIT_LO_W)) u_ex (
    .hi(exit_hi), .lo(exit_lo), .joined(exit_j));
  dls_field_join #(.HI_W(POST_HI_W), .LO_W(POST_LO_W)) u_po (
    .hi(post_hi), .lo(post_lo), .joined(post_j));

  assign zero_sel = lane_is_clk ? zero_clk : zero_dat;

  dls_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .esc_en      (esc_en),
    .lane_is_clk (lane_is_clk),
    .hs_request  (hs_request),
    .ta_request  (ta_request),
    .lpx_v       (CNT_W'(lpx_cnt)),
    .prep_v      (CNT_W'(prep_cnt)),
    .zero_v      (CNT_W'(zero_sel)),
    .trail_v     (CNT_W'(trail_cnt)),
    .exit_v      (CNT_W'(exit_j)),
    .post_v      (CNT_W'(post_j)),
    .pre_v       (CNT_W'(pre_cnt)),
    .ta_go_v     (CNT_W'(ta_go_cnt)),
    .ta_sure_v   (CNT_W'(ta_sure_cnt)),
    .ta_wait_v   (CNT_W'(ta_wait_cnt)),
    .ph          (ph),
    .ready       (hs_ready)
  );

  dls_line_map u_map (.ph(ph), .line(line));

  assign phase      = ph;
  assign lane_state = line;

  assert_line_ta_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_state == 3'd7) |-> (phase >= 4'd8));
  assert_ready_low_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd0) |-> !hs_ready);
endmodule

// File: tb/dphy_lane_seq_bench.sv
`timescale 1ns/1ps
module dphy_lane_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esc_en = 1'b0;
  logic lane_is_clk = 1'b0, hs_request = 1'b0, ta_request = 1'b0;
  logic [5:0] lpx_cnt = '0;
  logic [6:0] prep_cnt = '0;
  logic       zero_clk_hi = 1'b0, zero_dat_hi = 1'b0;
  logic [5:0] zero_clk_lo = '0, zero_dat_lo = '0;
  logic [6:0] trail_cnt = '0;
  logic       exit_hi = 1'b0;
  logic [4:0] exit_lo = '0;
  logic [1:0] post_hi = '0;
  logic [3:0] post_lo = '0;
  logic [3:0] pre_cnt = '0;
  logic [5:0] ta_go_cnt = '0, ta_sure_cnt = '0, ta_wait_cnt = '0;
  logic [2:0] lane_state;
  logic [3:0] phase;
  logic       hs_ready;

  int total = 0, bad = 0, cyc = 0, esc_ctr = 0;
  int m_ph = 0, m_left = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dphy_lane_seq u_dphy_lane_seq (
    .clk(clk), .rst_n(rst_n), .esc_en(esc_en), .lane_is_clk(lane_is_clk),
    .hs_request(hs_request), .ta_request(ta_request), .lpx_cnt(lpx_cnt),
    .prep_cnt(prep_cnt), .zero_clk_hi(zero_clk_hi), .zero_clk_lo(zero_clk_lo),
    .zero_dat_hi(zero_dat_hi), .zero_dat_lo(zero_dat_lo), .trail_cnt(trail_cnt),
    .exit_hi(exit_hi), .exit_lo(exit_lo), .post_hi(post_hi), .post_lo(post_lo),
    .pre_cnt(pre_cnt), .ta_go_cnt(ta_go_cnt), .ta_sure_cnt(ta_sure_cnt),
    .ta_wait_cnt(ta_wait_cnt), .lane_state(lane_state), .phase(phase),
    .hs_ready(hs_ready)
  );

  function automatic int d1(input int v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic int line_of(input int p);
    case (p)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4, 5: return 4;  6: return 5;  7: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic string tag_of(input int p, input bit clk_lane);
    case (p)
      0: return "R2";  1: return "R3";  2, 6: return "R4";  3: return "R5";
      4: return clk_lane ? "R7" : "R6";  5: return "R8";  7: return "R9";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference model, one step per byte-clock edge
  always @(posedge clk) begin
    int zsel;
    zsel = lane_is_clk ? (int'(zero_clk_hi) * 64 + int'(zero_clk_lo))
                       : (int'(zero_dat_hi) * 64 + int'(zero_dat_lo));
    if (!rst_n) begin
      m_ph = 0; m_left = 0;
    end else begin
      case (m_ph)
        0: if (hs_request) begin m_ph = 1; m_left = int'(lpx_cnt) + 1; end
           else if (ta_request) begin m_ph = 8; m_left = d1(int'(ta_go_cnt)); end
        1: if (m_left > 0) m_left--; else begin m_ph = 2; m_left = d1(int'(prep_cnt)); end
        2: if (m_left > 0) m_left--; else begin m_ph = 3; m_left = d1(zsel); end
        3: if (m_left > 0) m_left--;
           else begin m_ph = 4; m_left = lane_is_clk ? d1(int'(pre_cnt)) : 0; end
        4: if (m_left > 0) m_left--;
           else if (!hs_request) begin
             if (lane_is_clk) begin m_ph = 5; m_left = d1(int'(post_hi) * 16 + int'(post_lo)); end
             else begin m_ph = 6; m_left = d1(int'(trail_cnt)); end
           end
        5: if (m_left > 0) m_left--; else begin m_ph = 6; m_left = d1(int'(trail_cnt)); end
        6: if (m_left > 0) m_left--;
           else begin m_ph = 7; m_left = d1(int'(exit_hi) * 32 + int'(exit_lo)); end
        7: if (m_left > 0) m_left--; else m_ph = 0;
        8: if (esc_en) begin if (m_left > 0) m_left--; else begin m_ph = 9; m_left = d1(int'(ta_sure_cnt)); end end
        9: if (esc_en) begin if (m_left > 0) m_left--; else begin m_ph = 10; m_left = d1(int'(ta_wait_cnt)); end end
        default: if (esc_en) begin if (m_left > 0) m_left--; else m_ph = 0; end
      endcase
    end
  end

  // per-cycle comparison against the model (R11 line state checked everywhere)
  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      int exp_ln;
      bit exp_rdy;
      exp_ln  = line_of(m_ph);
      exp_rdy = (m_ph == 4) && (m_left == 0);
      total++;
      if (int'(phase) != m_ph || hs_ready !== exp_rdy) begin
        bad++;
        $display("FAIL %s cycle %0d: phase=%0d ready=%0b expected phase=%0d ready=%0b",
                 tag_of(m_ph, lane_is_clk), cyc, phase, hs_ready, m_ph, exp_rdy);
      end else if (int'(lane_state) != exp_ln) begin
        bad++;
        $display("FAIL R11 cycle %0d: lane_state=%0d expected %0d", cyc, lane_state, exp_ln);
      end
    end
  end

  always @(negedge clk) begin
    esc_ctr++;
    esc_en = (esc_ctr % 4 == 0);
  end

  task automatic finish_up();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      bad++;
      $display("FAIL watchdog: run still busy at cycle %0d, expected completion", cyc);
      finish_up();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while (int'(phase) != p);
  endtask

  // one high-speed burst; measures LPX length at the ports (R3)
  task automatic hs_burst(input int hold);
    int lpx_seen;
    @(negedge clk);
    hs_request = 1'b1;
    wait_phase(1);
    lpx_seen = 0;
    while (int'(phase) == 1) begin lpx_seen++; @(negedge clk); end
    check(lpx_seen == int'(lpx_cnt) + 2, "R3 lpx length", lpx_seen, int'(lpx_cnt) + 2);
    wait_phase(4);
    repeat (hold) @(negedge clk);
    hs_request = 1'b0;
    wait_phase(0);
  endtask

  task automatic ta_burst();
    @(negedge clk);
    ta_request = 1'b1;
    wait_phase(8);
    ta_request = 1'b0;
    wait_phase(0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(phase == 4'd0, "R1 phase in reset", phase, 0);
    check(lane_state == 3'd0, "R1 lane in reset", lane_state, 0);
    check(hs_ready == 1'b0, "R1 ready in reset", hs_ready, 0);
    rst_n = 1'b1;
    checking = 1'b1;
    @(negedge clk);
    check(phase == 4'd0 && lane_state == 3'd0, "R1 after reset", phase, 0);

    // R2: idle holds without a request
    repeat (5) @(negedge clk);
    check(phase == 4'd0, "R2 idle hold", phase, 0);

    // R4 R5 R6 R9: data lane, zero counts
    lane_is_clk = 1'b0; lpx_cnt = 0; prep_cnt = 0; zero_dat_lo = 5;
    trail_cnt = 3; exit_hi = 0; exit_lo = 0;
    zero_clk_lo = 40;
    hs_burst(6);

    // R3 R5 R9: maximum fields, data lane
    lpx_cnt = 63; prep_cnt = 127; zero_dat_hi = 1; zero_dat_lo = 0;
    trail_cnt = 0; exit_hi = 1; exit_lo = 31;
    hs_burst(2);

    // R7 R8: clock lane, drop before ready
    lane_is_clk = 1'b1; lpx_cnt = 1; prep_cnt = 2; zero_clk_hi = 0; zero_clk_lo = 7;
    pre_cnt = 5; post_hi = 2; post_lo = 1; trail_cnt = 4; exit_hi = 0; exit_lo = 2;
    hs_burst(1);

    // R7 R8: clock lane, zero pre/post, full zero field
    pre_cnt = 0; post_hi = 0; post_lo = 0; zero_clk_hi = 1; zero_clk_lo = 63;
    hs_burst(3);

    // R10: turnaround with slow escape ticks
    ta_go_cnt = 0; ta_sure_cnt = 5; ta_wait_cnt = 63;
    ta_burst();
    check(phase == 4'd0, "R10 back to idle", phase, 0);

    // R2: both requests together take the high-speed path
    lane_is_clk = 1'b0; lpx_cnt = 2; zero_dat_hi = 0; zero_dat_lo = 1;
    @(negedge clk);
    hs_request = 1'b1; ta_request = 1'b1;
    @(negedge clk);
    check(phase == 4'd1, "R2 hs priority", phase, 1);
    ta_request = 1'b0;
    wait_phase(4);
    hs_request = 1'b0;
    wait_phase(0);

    // R10: minimal turnaround
    ta_sure_cnt = 0; ta_wait_cnt = 1;
    ta_burst();

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule